// File: doc/BRIEF.md
# Serial Receive-Error and Transmit-Status Flag Block

This block keeps the error and line-status flags of a serial controller that can run in asynchronous, byte-oriented synchronous or bit-oriented framing. The receiver and transmitter datapaths report events to it as single-cycle strobes: a received character with its parity bit, a FIFO overwrite, a CRC or framing fault, a frame end with its residue count, and an abort sequence. The transmitter also reports a level that shows when its shifter is empty.

The host controls the block through command writes. A 3-bit command field taken from bits 5:3 of the written byte can clear the receive error flags or the external/status flag. The block returns two status bytes and an interrupt request. Which bits of the two bytes carry meaning depends on the selected mode. Error flags are sticky. If an event and the command that clears it arrive in the same cycle, the event wins.

Top module: `sio_status_flags`

## Requirements
- R1: While reset is asserted and just after it is released, `stat0_o` reads 8'h00, `stat1_o` reads 8'h01 (mode 2'b00) and `irq_o` is 0.
- R2: `stat1_o[4]` (parity error) sets one cycle after a `rx_char_stb_i` with `par_en_i`=1 when the XOR of `rx_data_i` and `rx_par_i` differs from `par_odd_i` (0 = even sense, 1 = odd sense). It does not set when `par_en_i`=0.
- R3: The parity, overrun, CRC/framing and end-of-frame flags hold once set. They clear on the cycle after a write whose bits 5:3 equal 3'b110. A write with any other code leaves them unchanged.
- R4: `stat1_o[5]` (overrun) sets one cycle after `rx_ovr_stb_i`.
- R5: `stat1_o[6]` (CRC/framing) sets one cycle after `crc_err_stb_i` in any mode. `stat1_o[7]` (end of frame) sets one cycle after `eof_stb_i` only when mode is 2'b10.
- R6: If a set strobe and its clear command arrive in the same cycle, the flag is 1 on the following cycle.
- R7: `stat0_o[7]` (abort) sets one cycle after `abort_stb_i` in mode 2'b10. It clears on the cycle after a write whose bits 5:3 equal 3'b010. It reads 0 in any mode other than 2'b10. Bits 6:0 of `stat0_o` read 0.
- R8: `stat1_o[0]` (all sent) equals `tx_idle_i` delayed by one cycle in mode 2'b00. It reads 1 in every other mode.
- R9: `stat1_o[3:1]` returns the `residue_i` value captured at the last `eof_stb_i` in mode 2'b10 (0 after reset). It reads 0 outside mode 2'b10.
- R10: `irq_o` is 1 exactly when `err_ie_i`=1 and at least one of the parity, overrun or CRC/framing flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 async, 01 byte sync, 10 bit-oriented, 11 treated as byte sync |
| par_en_i | input | 1 | Parity checking enable |
| par_odd_i | input | 1 | Parity sense, 1 = odd |
| err_ie_i | input | 1 | Error interrupt enable |
| rx_char_stb_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character bits |
| rx_par_i | input | 1 | Received parity bit |
| rx_ovr_stb_i | input | 1 | Receive FIFO overwrite strobe |
| crc_err_stb_i | input | 1 | CRC or framing error strobe |
| eof_stb_i | input | 1 | End-of-frame strobe |
| residue_i | input | 3 | Residue code presented with end of frame |
| abort_stb_i | input | 1 | Abort sequence strobe |
| tx_idle_i | input | 1 | Transmit shifter and holding stage empty |
| wr_en_i | input | 1 | Host command write strobe |
| wr_data_i | input | 8 | Host command byte, code in bits 5:3 |
| stat0_o | output | 8 | First status byte |
| stat1_o | output | 8 | Second status byte |
| irq_o | output | 1 | Error interrupt request |

## Verification
Most of the run is seeded random traffic. Each cycle it drives every strobe at a low rate and sends host writes with arbitrary bytes, and it changes mode and the interrupt enable from time to time. A cycle-level model compares each field of both bytes on every cycle. Because any command code can appear, this traffic separates a decoder that reads the wrong field or code from a correct one. Because the mode changes while flags are held, it also catches masking applied at the wrong point, for example on the stored abort flag instead of at the output.

Directed cases cover the rest:
- a set strobe and its clear command in the same cycle;
- clear attempts with the neighbouring code;
- every combination of parity sense and parity bit;
- parity events with checking disabled;
- residue capture outside bit-oriented mode.

// File: rtl/sio_status_pkg.sv
package sio_status_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC     = 2'b00,
    MODE_BYTE_SYNC = 2'b01,
    MODE_BIT_SYNC  = 2'b10,
    MODE_RSVD      = 2'b11
  } sio_mode_e;

  localparam int CMD_LSB = 3;
  localparam int CMD_W   = 3;
  localparam logic [CMD_W-1:0] CMD_RST_EXT = 3'd2;
  localparam logic [CMD_W-1:0] CMD_RST_ERR = 3'd6;

  localparam int RES_W = 3;

  // index of each error-class sticky flag
  localparam int ERR_PAR    = 0;
  localparam int ERR_OVR    = 1;
  localparam int ERR_CRC    = 2;
  localparam int ERR_EOF    = 3;
  localparam int NUM_STICKY = 4;

endpackage

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
  import sio_status_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          ext_rst_o,
  output logic          err_rst_o
);

  logic [CMD_W-1:0] code;

  always_comb begin
    code      = wr_data_i[CMD_LSB +: CMD_W];
    ext_rst_o = wr_en_i && (code == CMD_RST_EXT);
    err_rst_o = wr_en_i && (code == CMD_RST_ERR);
  end

endmodule

// File: rtl/sio_sticky_bit.sv
module sio_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_d;
  logic q_q;

  // set has priority over clear so that no event is lost
  always_comb begin
    q_d = q_q;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/sio_line_state.sv
module sio_line_state
  import sio_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_idle_i,
  input  logic             res_load_i,
  input  logic [RES_W-1:0] residue_i,
  output logic             sent_o,
  output logic [RES_W-1:0] residue_o
);

  logic             sent_d, sent_q;
  logic [RES_W-1:0] res_d, res_q;

  always_comb begin
    sent_d = tx_idle_i;
    res_d  = res_q;
    if (res_load_i) res_d = residue_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= 1'b1;
      res_q  <= '0;
    end else begin
      sent_q <= sent_d;
      if (res_load_i) res_q <= res_d;
    end
  end

  assign sent_o    = sent_q;
  assign residue_o = res_q;

endmodule

// File: rtl/sio_status_flags.sv
module sio_status_flags
  import sio_status_pkg::*;
#(
  parameter int DW     = 8,
  parameter bit IRQ_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          err_ie_i,
  input  logic          rx_char_stb_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_par_i,
  input  logic          rx_ovr_stb_i,
  input  logic          crc_err_stb_i,
  input  logic          eof_stb_i,
  input  logic [2:0]    residue_i,
  input  logic          abort_stb_i,
  input  logic          tx_idle_i,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  output logic [7:0]    stat0_o,
  output logic [7:0]    stat1_o,
  output logic          irq_o
);

  sio_mode_e mode;
  logic      is_async, is_bit;
  logic      ext_rst, err_rst;
  logic      par_bad;
  logic [NUM_STICKY-1:0] err_set, err_q;
  logic      abort_set, abort_q;
  logic      sent_q;
  logic [RES_W-1:0] res_q;

  always_comb begin
    mode     = sio_mode_e'(mode_i);
    is_async = (mode == MODE_ASYNC);
    is_bit   = (mode == MODE_BIT_SYNC);
  end

  sio_cmd_decode #(.DW(8)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ext_rst_o (ext_rst),
    .err_rst_o (err_rst)
  );

  // received word including its parity bit must have the programmed sense
  always_comb begin
    par_bad = ((^{rx_data_i, rx_par_i}) != par_odd_i);
    err_set           = '0;
    err_set[ERR_PAR]  = rx_char_stb_i && par_en_i && par_bad;
    err_set[ERR_OVR]  = rx_ovr_stb_i;
    err_set[ERR_CRC]  = crc_err_stb_i;
    err_set[ERR_EOF]  = eof_stb_i && is_bit;
    abort_set         = abort_stb_i && is_bit;
  end

  for (genvar gi = 0; gi < NUM_STICKY; gi++) begin : g_err
    sio_sticky_bit u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (err_set[gi]),
      .clr_i (err_rst),
      .q_o   (err_q[gi])
    );
  end

  sio_sticky_bit u_abort (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (abort_set),
    .clr_i (ext_rst),
    .q_o   (abort_q)
  );

  sio_line_state u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_idle_i  (tx_idle_i),
    .res_load_i (eof_stb_i && is_bit),
    .residue_i  (residue_i),
    .sent_o     (sent_q),
    .residue_o  (res_q)
  );

  always_comb begin
    stat0_o    = '0;
    stat0_o[7] = abort_q && is_bit;
    stat1_o    = {err_q[ERR_EOF], err_q[ERR_CRC], err_q[ERR_OVR], err_q[ERR_PAR],
                  (is_bit ? res_q : '0),
                  (is_async ? sent_q : 1'b1)};
  end

  if (IRQ_EN) begin : g_irq
    assign irq_o = err_ie_i && (err_q[ERR_PAR] || err_q[ERR_OVR] || err_q[ERR_CRC]);
  end else begin : g_no_irq
    assign irq_o = 1'b0;
  end

endmodule

// File: rtl/sio_status_flags_chk.sv
module sio_status_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       err_ie_i,
  input logic       rx_ovr_stb_i,
  input logic       crc_err_stb_i,
  input logic       abort_stb_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] stat0_o,
  input logic [7:0] stat1_o,
  input logic       irq_o
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_vals_r1: assert (stat0_o == 8'h00 && irq_o == 1'b0)
        else $error("reset values wrong");
    end
  end

  p_par_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat1_o[4] && !(wr_en_i && wr_data_i[5:3] == 3'd6)) |=> stat1_o[4]);

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr_stb_i |=> stat1_o[5]);

  p_crc_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err_stb_i && wr_en_i && wr_data_i[5:3] == 3'd6) |=> stat1_o[6]);

  p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[5:3] == 3'd2 && !abort_stb_i) |=> !stat0_o[7]);

  p_abort_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b10) |-> (stat0_o == 8'h00));

  p_sync_sent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b00) |-> stat1_o[0]);

  p_res_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b10) |-> (stat1_o[3:1] == 3'b000));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_ie_i || stat1_o[6:4] == 3'b000) |-> !irq_o);

endmodule

bind sio_status_flags sio_status_flags_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_i        (mode_i),
  .err_ie_i      (err_ie_i),
  .rx_ovr_stb_i  (rx_ovr_stb_i),
  .crc_err_stb_i (crc_err_stb_i),
  .abort_stb_i   (abort_stb_i),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .stat0_o       (stat0_o),
  .stat1_o       (stat1_o),
  .irq_o         (irq_o)
);

// File: tb/sio_status_flags_test.sv
`timescale 1ns/1ps
module sio_status_flags_test;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode_i;
  logic       par_en_i, par_odd_i, err_ie_i;
  logic       rx_char_stb_i;
  logic [7:0] rx_data_i;
  logic       rx_par_i, rx_ovr_stb_i, crc_err_stb_i, eof_stb_i;
  logic [2:0] residue_i;
  logic       abort_stb_i, tx_idle_i, wr_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] stat0_o, stat1_o;
  logic       irq_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference state
  bit m_par, m_ovr, m_crc, m_eof, m_abort, m_sent;
  bit [2:0] m_res;

  sio_status_flags uut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic bit parity_wrong(bit [7:0] d, bit pb, bit odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    ones += pb;
    return (ones % 2) != (odd ? 1 : 0);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_char_stb_i = 0; rx_ovr_stb_i = 0; crc_err_stb_i = 0; eof_stb_i = 0;
    abort_stb_i = 0; wr_en_i = 0;
  endtask

  // advance one edge, update the model, compare every field
  task automatic step();
    bit [2:0] code;
    @(posedge clk);
    code = wr_data_i[5:3];
    if (wr_en_i && code == 3'd6) begin m_par = 0; m_ovr = 0; m_crc = 0; m_eof = 0; end
    if (wr_en_i && code == 3'd2) m_abort = 0;
    if (rx_char_stb_i && par_en_i && parity_wrong(rx_data_i, rx_par_i, par_odd_i)) m_par = 1;
    if (rx_ovr_stb_i) m_ovr = 1;
    if (crc_err_stb_i) m_crc = 1;
    if (eof_stb_i && mode_i == 2'b10) begin m_eof = 1; m_res = residue_i; end
    if (abort_stb_i && mode_i == 2'b10) m_abort = 1;
    m_sent = tx_idle_i;
    #1;
    chk("R2 parity bit",   {7'b0, stat1_o[4]}, {7'b0, m_par});
    chk("R4 overrun bit",  {7'b0, stat1_o[5]}, {7'b0, m_ovr});
    chk("R5 crc/eof bits", {6'b0, stat1_o[7:6]}, {6'b0, m_eof, m_crc});
    chk("R7 abort byte",   stat0_o, {(m_abort && mode_i == 2'b10), 7'b0});
    chk("R8 all sent",     {7'b0, stat1_o[0]}, {7'b0, (mode_i == 2'b00) ? m_sent : 1'b1});
    chk("R9 residue",      {5'b0, stat1_o[3:1]}, {5'b0, (mode_i == 2'b10) ? m_res : 3'b0});
    chk("R10 irq",         {7'b0, irq_o}, {7'b0, err_ie_i && (m_par || m_ovr || m_crc)});
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic write_cmd(bit [2:0] code);
    wr_en_i = 1; wr_data_i = {2'b01, code, 3'b101};
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; mode_i = 2'b00; par_en_i = 1; par_odd_i = 0; err_ie_i = 1;
    rx_data_i = 0; rx_par_i = 0; residue_i = 0; tx_idle_i = 1; wr_data_i = 0;
    idle_inputs();
    m_par = 0; m_ovr = 0; m_crc = 0; m_eof = 0; m_abort = 0; m_sent = 1; m_res = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset stat0", stat0_o, 8'h00);
    chk("R1 reset stat1", stat1_o, 8'h01);
    chk("R1 reset irq",   {7'b0, irq_o}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release stat1", stat1_o, 8'h01);

    // R2: every parity sense and bit combination
    for (int s = 0; s < 2; s++) begin
      for (int b = 0; b < 2; b++) begin
        par_odd_i = s[0]; rx_data_i = 8'hA7; rx_par_i = b[0]; rx_char_stb_i = 1;
        step();
        write_cmd(3'd6); step();
      end
    end
    // R2: disabled checking never sets
    par_en_i = 0; par_odd_i = 0; rx_data_i = 8'h01; rx_par_i = 0; rx_char_stb_i = 1;
    step();
    chk("R2 disabled parity", {7'b0, stat1_o[4]}, 8'h00);
    par_en_i = 1;

    // R3: neighbouring code leaves errors, correct code clears
    rx_ovr_stb_i = 1; crc_err_stb_i = 1; step();
    write_cmd(3'd7); step();
    write_cmd(3'd2); step();
    chk("R3 wrong code keeps flags", {6'b0, stat1_o[6:5]}, 8'h03);
    write_cmd(3'd6); step();
    chk("R3 error reset clears", {6'b0, stat1_o[6:5]}, 8'h00);

    // R6: set and clear together
    rx_ovr_stb_i = 1; write_cmd(3'd6); step();
    chk("R6 set wins overrun", {7'b0, stat1_o[5]}, 8'h01);
    write_cmd(3'd6); step();

    // R7/R9: bit-oriented mode, abort and residue
    mode_i = 2'b10;
    abort_stb_i = 1; eof_stb_i = 1; residue_i = 3'd5; step();
    chk("R7 abort set", stat0_o, 8'h80);
    chk("R9 residue captured", {5'b0, stat1_o[3:1]}, 8'h05);
    abort_stb_i = 1; write_cmd(3'd2); step();
    chk("R6 set wins abort", stat0_o, 8'h80);
    write_cmd(3'd6); step();
    chk("R7 error reset keeps abort", stat0_o, 8'h80);
    mode_i = 2'b01; step();
    chk("R7 abort masked byte sync", stat0_o, 8'h00);
    eof_stb_i = 1; residue_i = 3'd2; step();
    mode_i = 2'b10; step();
    chk("R9 residue not loaded outside bit mode", {5'b0, stat1_o[3:1]}, 8'h05);
    write_cmd(3'd2); step();
    chk("R7 ext reset clears abort", stat0_o, 8'h00);

    // R8: all sent tracks idle in async
    mode_i = 2'b00; tx_idle_i = 0; step();
    chk("R8 busy shifter", {7'b0, stat1_o[0]}, 8'h00);
    tx_idle_i = 1; step();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 64) == 0) mode_i = 2'($urandom);
      if (($urandom % 32) == 0) err_ie_i = 1'($urandom);
      if (($urandom % 32) == 0) par_en_i = 1'($urandom);
      if (($urandom % 32) == 0) par_odd_i = 1'($urandom);
      if (($urandom % 4) == 0) tx_idle_i = 1'($urandom);
      rx_char_stb_i = (($urandom % 6) == 0);
      rx_data_i     = 8'($urandom);
      rx_par_i      = 1'($urandom);
      rx_ovr_stb_i  = (($urandom % 20) == 0);
      crc_err_stb_i = (($urandom % 20) == 0);
      eof_stb_i     = (($urandom % 12) == 0);
      residue_i     = 3'($urandom);
      abort_stb_i   = (($urandom % 16) == 0);
      wr_en_i       = (($urandom % 6) == 0);
      wr_data_i     = 8'($urandom);
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule